// File: doc/BRIEF.md
# PIO-during-DMA Access Guard

This block sits between a host I/O port and the register file of an IDE-style storage device. A programmed-I/O (PIO) register access is dangerous while a DMA command is running. The block detects such accesses and, depending on its settings, does one of three things: it passes them to the device, it swallows them and returns a fixed read value, or it reports them as an error or as a system-management interrupt (SMI) request.

The block also gathers several error sources into sticky flags, and each flag has its own enable. The sources are an unexpected transaction type, an exception marker in a response, a PIO access during DMA, an I/O write during DMA while blocking is on, and an SMI that is raised again before software has acknowledged the last one. The enabled error-class flags drive one level-style error output.

Software works the block through a single 64-bit control/status register. The register holds the enables, a blocking control and the write-1-to-clear flags.

Top module: `pio_dma_guard`

## Requirements
- R1: The control/status register resets to all zeros. Bits 0..4 are enables, bit 8 is the block control and bits 32..36 are flags (flag 32+i belongs to enable i). Every other bit reads 0 and ignores writes. Enables and the block bit read back what was last written.
- R2: Writing 1 to a flag bit clears that flag. Writing 0 to a flag bit leaves it unchanged.
- R3: A flag never sets while its enable is 0. The event is then ignored for the flag, for `err_o` and for the SMI from enable 1.
- R4: When the block bit is 1, enable 4 is 0 and `smi_pio_en` is 0, a PIO access during DMA (`host_req` with `dma_active`) blocks in the same cycle. A write does not reach the device (`dev_req` low). A read returns 0x80 on `host_rdata`, with `dev_req` low.
- R5: When the block bit is 0, or when `dma_active` is 0, a PIO access passes through unchanged: `dev_req`, `dev_wr`, `dev_addr`, `dev_wdata` follow the host, and `host_rdata` equals `dev_rdata`.
- R6: With enable 0 set, a pulse on `unexp_type` sets flag 32 on the next clock edge. With enable 3 set, a pulse on `resp_excep` sets flag 35 on the next clock edge.
- R7: `err_o` is high exactly while any of flags 32, 34, 35, 36 is set together with its enable. It drops in the cycle after the write that clears them. Flag 33 does not drive `err_o`.
- R8: With enable 4 set, any PIO access during DMA sets flag 36 and raises `err_o`. The access is not blocked.
- R9: With the block bit and enable 1 set, a PIO write during DMA sets flag 33 and raises `smi_req` on the next edge. The write itself is still blocked when R4's conditions hold.
- R10: `smi_req` stays high until a cycle with `smi_ack` high. A new SMI in the same cycle as the acknowledge keeps it high.
- R11: With enable 2 set, an SMI raised while `smi_req` is already high and not being acknowledged sets flag 34.
- R12: When an event and a write-1-to-clear of its flag land in the same cycle, the flag stays set.
- R13: With `smi_pio_en` high, any PIO access during DMA raises `smi_req` and passes to the device.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_wr_en | input | 1 | Control/status register write strobe |
| csr_wr_data | input | 64 | Control/status register write value |
| csr_rd_data | output | 64 | Control/status register contents |
| host_req | input | 1 | Host PIO access valid |
| host_wr | input | 1 | Host access is a write |
| host_addr | input | 4 | Host device-register address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data returned to host |
| dev_req | output | 1 | Access forwarded to device |
| dev_wr | output | 1 | Forwarded access is a write |
| dev_addr | output | 4 | Forwarded address |
| dev_wdata | output | 8 | Forwarded write data |
| dev_rdata | input | 8 | Device read data |
| dma_active | input | 1 | A DMA command is in progress |
| unexp_type | input | 1 | Unexpected transaction type strobe |
| resp_excep | input | 1 | Response exception marker strobe |
| smi_pio_en | input | 1 | Raise an SMI on any PIO access during DMA |
| smi_ack | input | 1 | SMI acknowledge |
| err_o | output | 1 | Master error level |
| smi_req | output | 1 | SMI request level |

## Verification
The access path is combinational. The blocking and pass-through results of R4 and R5 are therefore due in the same cycle as the request, and the bench samples them one time unit after it drives the request mid-cycle. Flags and `smi_req` are registered. They change on the first rising edge after their event or write, so the bench applies each stimulus for one full cycle from a falling edge and reads the register and the outputs at the next falling edge. `err_o` is combinational from the flag register and is checked in that same sample.

// File: rtl/pio_guard_pkg.sv
package pio_guard_pkg;
   localparam int N_SRC     = 5;
   localparam int FLAG_BASE = 32;
   localparam int BLK_BIT   = 8;

   localparam int SRC_UNEXP = 0;
   localparam int SRC_IOWR  = 1;
   localparam int SRC_STALE = 2;
   localparam int SRC_RESP  = 3;
   localparam int SRC_PIO   = 4;

   // sources that feed the master error level (flag 33 only drives the SMI)
   localparam logic [N_SRC-1:0] ERR_CLASS = 5'b11101;

   typedef struct packed {
      logic         req;
      logic         wr;
   } acc_ctl_t;
endpackage

// File: rtl/pio_guard_csr.sv
module pio_guard_csr
   import pio_guard_pkg::*;
#(
   parameter int CSR_W = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [CSR_W-1:0] wr_data,
   input  logic [N_SRC-1:0] ev,
   output logic [N_SRC-1:0] en_o,
   output logic             blk_o,
   output logic [N_SRC-1:0] flag_o,
   output logic [CSR_W-1:0] rd_data
);
   localparam int TOP_USED = FLAG_BASE + N_SRC;

   if (CSR_W < TOP_USED) begin : g_width_bad
      $error("pio_guard_csr: CSR_W too small for flag field");
   end

   logic [N_SRC-1:0] en_q;
   logic             blk_q;
   logic [N_SRC-1:0] flag_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q  <= '0;
         blk_q <= 1'b0;
      end else if (wr_en) begin
         en_q  <= wr_data[N_SRC-1:0];
         blk_q <= wr_data[BLK_BIT];
      end
   end

   for (genvar i = 0; i < N_SRC; i++) begin : g_flag
      logic q;
      logic clr;
      logic set;
      assign clr = wr_en & wr_data[FLAG_BASE+i];
      assign set = ev[i] & en_q[i];
      always_ff @(posedge clk) begin
         if (!rst_n) q <= 1'b0;
         else        q <= set | (q & ~clr);
      end
      assign flag_q[i] = q;
   end

   always_comb begin
      rd_data                     = '0;
      rd_data[N_SRC-1:0]          = en_q;
      rd_data[BLK_BIT]            = blk_q;
      rd_data[FLAG_BASE +: N_SRC] = flag_q;
   end

   assign en_o   = en_q;
   assign blk_o  = blk_q;
   assign flag_o = flag_q;
endmodule

// File: rtl/pio_guard_path.sv
module pio_guard_path
   import pio_guard_pkg::*;
#(
   parameter int          ADDR_W      = 4,
   parameter int          DATA_W      = 8,
   parameter logic [7:0]  BLOCK_RD    = 8'h80,
   parameter bit          DEV_QUIET   = 1'b1
) (
   input  logic              host_req,
   input  logic              host_wr,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   output logic              dev_req,
   output logic              dev_wr,
   output logic [ADDR_W-1:0] dev_addr,
   output logic [DATA_W-1:0] dev_wdata,
   input  logic [DATA_W-1:0] dev_rdata,
   input  logic              dma_active,
   input  logic              blk,
   input  logic              pio_err_en,
   input  logic              smi_pio_en,
   output logic              pio_dma,
   output logic              pio_wr_dma
);
   localparam logic [DATA_W-1:0] FAKE_RD = DATA_W'(BLOCK_RD);

   if (DATA_W < 8) begin : g_data_bad
      $error("pio_guard_path: DATA_W must be at least 8");
   end
   if (ADDR_W < 1) begin : g_addr_bad
      $error("pio_guard_path: ADDR_W must be positive");
   end

   acc_ctl_t ctl;
   logic     blocked;

   assign pio_dma    = host_req & dma_active;
   assign pio_wr_dma = pio_dma & host_wr;
   assign blocked    = pio_dma & blk & ~pio_err_en & ~smi_pio_en;

   always_comb begin
      ctl.req = host_req & ~blocked;
      ctl.wr  = host_wr;
   end

   assign dev_req    = ctl.req;
   assign host_rdata = blocked ? FAKE_RD : dev_rdata;

   if (DEV_QUIET) begin : g_quiet
      assign dev_wr    = ctl.req & ctl.wr;
      assign dev_addr  = ctl.req ? host_addr  : '0;
      assign dev_wdata = ctl.req ? host_wdata : '0;
   end else begin : g_raw
      assign dev_wr    = ctl.wr;
      assign dev_addr  = host_addr;
      assign dev_wdata = host_wdata;
   end
endmodule

// File: rtl/pio_guard_smi.sv
module pio_guard_smi (
   input  logic clk,
   input  logic rst_n,
   input  logic raise_wr,
   input  logic raise_pio,
   input  logic ack,
   output logic smi_req,
   output logic stale
);
   logic raise;
   logic req_q;

   assign raise = raise_wr | raise_pio;
   assign stale = raise & req_q & ~ack;

   always_ff @(posedge clk) begin
      if (!rst_n) req_q <= 1'b0;
      else        req_q <= raise | (req_q & ~ack);
   end

   assign smi_req = req_q;
endmodule

// File: rtl/pio_dma_guard.sv
module pio_dma_guard
   import pio_guard_pkg::*;
#(
   parameter int         CSR_W     = 64,
   parameter int         ADDR_W    = 4,
   parameter int         DATA_W    = 8,
   parameter logic [7:0] BLOCK_RD  = 8'h80,
   parameter bit         DEV_QUIET = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              csr_wr_en,
   input  logic [CSR_W-1:0]  csr_wr_data,
   output logic [CSR_W-1:0]  csr_rd_data,
   input  logic              host_req,
   input  logic              host_wr,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   output logic              dev_req,
   output logic              dev_wr,
   output logic [ADDR_W-1:0] dev_addr,
   output logic [DATA_W-1:0] dev_wdata,
   input  logic [DATA_W-1:0] dev_rdata,
   input  logic              dma_active,
   input  logic              unexp_type,
   input  logic              resp_excep,
   input  logic              smi_pio_en,
   input  logic              smi_ack,
   output logic              err_o,
   output logic              smi_req
);
   logic [N_SRC-1:0] en;
   logic [N_SRC-1:0] flag;
   logic [N_SRC-1:0] ev;
   logic             blk;
   logic             pio_dma;
   logic             pio_wr_dma;
   logic             stale;
   logic             iowr_ev;

   pio_guard_csr #(.CSR_W(CSR_W)) u_csr (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (csr_wr_en),
      .wr_data (csr_wr_data),
      .ev      (ev),
      .en_o    (en),
      .blk_o   (blk),
      .flag_o  (flag),
      .rd_data (csr_rd_data)
   );

   pio_guard_path #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .BLOCK_RD  (BLOCK_RD),
      .DEV_QUIET (DEV_QUIET)
   ) u_path (
      .host_req   (host_req),
      .host_wr    (host_wr),
      .host_addr  (host_addr),
      .host_wdata (host_wdata),
      .host_rdata (host_rdata),
      .dev_req    (dev_req),
      .dev_wr     (dev_wr),
      .dev_addr   (dev_addr),
      .dev_wdata  (dev_wdata),
      .dev_rdata  (dev_rdata),
      .dma_active (dma_active),
      .blk        (blk),
      .pio_err_en (en[SRC_PIO]),
      .smi_pio_en (smi_pio_en),
      .pio_dma    (pio_dma),
      .pio_wr_dma (pio_wr_dma)
   );

   assign iowr_ev = pio_wr_dma & blk;

   pio_guard_smi u_smi (
      .clk       (clk),
      .rst_n     (rst_n),
      .raise_wr  (iowr_ev & en[SRC_IOWR]),
      .raise_pio (smi_pio_en & pio_dma),
      .ack       (smi_ack),
      .smi_req   (smi_req),
      .stale     (stale)
   );

   always_comb begin
      ev            = '0;
      ev[SRC_UNEXP] = unexp_type;
      ev[SRC_IOWR]  = iowr_ev;
      ev[SRC_STALE] = stale;
      ev[SRC_RESP]  = resp_excep;
      ev[SRC_PIO]   = pio_dma;
   end

   assign err_o = |(flag & en & ERR_CLASS);
endmodule

// File: rtl/pio_dma_guard_chk.sv
module pio_dma_guard_chk #(
   parameter int CSR_W = 64
) (
   input logic             clk,
   input logic             rst_n,
   input logic             csr_wr_en,
   input logic [CSR_W-1:0] csr_wr_data,
   input logic [CSR_W-1:0] csr_rd_data,
   input logic             host_req,
   input logic             dma_active,
   input logic             dev_req,
   input logic             unexp_type,
   input logic             resp_excep,
   input logic             smi_pio_en,
   input logic             smi_ack,
   input logic             err_o,
   input logic             smi_req
);
   localparam logic [CSR_W-1:0] USED = CSR_W'(64'h0000_001F_0000_011F);

   logic quiet;
   assign quiet = !unexp_type && !resp_excep && !(host_req && dma_active);

   // R1
   reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_rd_data & ~USED) == '0);

   // R2
   w0_keeps_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      csr_wr_en |=> (($past(csr_rd_data[36:32]) & ~$past(csr_wr_data[36:32]))
                     & ~csr_rd_data[36:32]) == 5'd0);

   // R3
   no_set_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((~$past(csr_rd_data[36:32]) & csr_rd_data[36:32]
                 & ~$past(csr_rd_data[4:0])) == 5'd0));

   // R4
   block_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (host_req && dma_active && csr_rd_data[8] && !csr_rd_data[4] && !smi_pio_en)
      |-> !dev_req);

   // R5
   idle_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dma_active |-> (dev_req == host_req));

   // R7
   err_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_wr_en && (&csr_wr_data[36:32]) && quiet) |=> !err_o);

   // R10
   smi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (smi_req && !smi_ack) |=> smi_req);
endmodule

bind pio_dma_guard pio_dma_guard_chk #(.CSR_W(CSR_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .csr_wr_en   (csr_wr_en),
   .csr_wr_data (csr_wr_data),
   .csr_rd_data (csr_rd_data),
   .host_req    (host_req),
   .dma_active  (dma_active),
   .dev_req     (dev_req),
   .unexp_type  (unexp_type),
   .resp_excep  (resp_excep),
   .smi_pio_en  (smi_pio_en),
   .smi_ack     (smi_ack),
   .err_o       (err_o),
   .smi_req     (smi_req)
);

// File: tb/pio_dma_guard_test.sv
module pio_dma_guard_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        csr_wr_en = 1'b0;
   logic [63:0] csr_wr_data = '0;
   logic [63:0] csr_rd_data;
   logic        host_req = 1'b0;
   logic        host_wr = 1'b0;
   logic [3:0]  host_addr = '0;
   logic [7:0]  host_wdata = '0;
   logic [7:0]  host_rdata;
   logic        dev_req;
   logic        dev_wr;
   logic [3:0]  dev_addr;
   logic [7:0]  dev_wdata;
   logic [7:0]  dev_rdata = '0;
   logic        dma_active = 1'b0;
   logic        unexp_type = 1'b0;
   logic        resp_excep = 1'b0;
   logic        smi_pio_en = 1'b0;
   logic        smi_ack = 1'b0;
   logic        err_o;
   logic        smi_req;

   int checks = 0;
   int fails  = 0;

   always #5 clk = ~clk;

   pio_dma_guard uut (
      .clk(clk), .rst_n(rst_n), .csr_wr_en(csr_wr_en), .csr_wr_data(csr_wr_data),
      .csr_rd_data(csr_rd_data), .host_req(host_req), .host_wr(host_wr),
      .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .dev_req(dev_req), .dev_wr(dev_wr), .dev_addr(dev_addr), .dev_wdata(dev_wdata),
      .dev_rdata(dev_rdata), .dma_active(dma_active), .unexp_type(unexp_type),
      .resp_excep(resp_excep), .smi_pio_en(smi_pio_en), .smi_ack(smi_ack),
      .err_o(err_o), .smi_req(smi_req)
   );

   task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; host_req = 0; host_wr = 0; dma_active = 0; unexp_type = 0;
      resp_excep = 0; smi_pio_en = 0; smi_ack = 0; csr_wr_en = 0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic csr_write(input logic [63:0] d);
      csr_wr_en = 1'b1; csr_wr_data = d;
      @(negedge clk);
      csr_wr_en = 1'b0; csr_wr_data = '0;
   endtask

   task automatic pio(input logic wr);
      host_req = 1'b1; host_wr = wr; host_addr = 4'h7; host_wdata = 8'h5A;
      @(negedge clk);
      host_req = 1'b0; host_wr = 1'b0;
   endtask

   task automatic t_reset();
      do_reset();
      chk(csr_rd_data, 64'h0, "R1 reset csr");
      chk({63'd0, err_o}, 64'h0, "R1 reset err");
      chk({63'd0, smi_req}, 64'h0, "R1 reset smi");
   endtask

   task automatic t_csr();
      do_reset();
      csr_write('1);
      chk(csr_rd_data, 64'h0000_0000_0000_011F, "R1 readback reserved zero");
      csr_write(64'h0);
      chk(csr_rd_data, 64'h0, "R1 readback cleared");
   endtask

   task automatic t_pass();
      do_reset();
      dma_active = 1'b1; dev_rdata = 8'h3C;
      host_req = 1; host_wr = 1; host_addr = 4'h9; host_wdata = 8'hA5;
      #1;
      chk({dev_req, dev_wr, dev_addr, dev_wdata}, {1'b1, 1'b1, 4'h9, 8'hA5}, "R5 write passes blk=0");
      host_wr = 0;
      #1;
      chk({56'd0, host_rdata}, 64'h3C, "R5 read passes blk=0");
      @(negedge clk);
      host_req = 0;
      dma_active = 0;
      csr_write(64'h100);
      host_req = 1; host_wr = 0; #1;
      chk({dev_req, host_rdata}, {1'b1, 8'h3C}, "R5 no dma passes blk=1");
      @(negedge clk);
      host_req = 0;
   endtask

   task automatic t_block();
      do_reset();
      csr_write(64'h100);
      dma_active = 1'b1; dev_rdata = 8'h3C;
      host_req = 1; host_wr = 1; #1;
      chk({63'd0, dev_req}, 64'h0, "R4 write swallowed");
      host_wr = 0; #1;
      chk({55'd0, dev_req, host_rdata}, {55'd0, 1'b0, 8'h80}, "R4 read fake value");
      @(negedge clk);
      host_req = 0;
      chk({err_o, smi_req, csr_rd_data[36:32]}, 7'd0, "R4 no err no smi");
      dma_active = 0;
   endtask

   task automatic t_gate();
      do_reset();
      dma_active = 1;
      unexp_type = 1; resp_excep = 1; host_req = 1; host_wr = 1;
      @(negedge clk);
      unexp_type = 0; resp_excep = 0; host_req = 0; host_wr = 0;
      chk({err_o, smi_req, csr_rd_data[36:32]}, 7'd0, "R3 disabled events ignored");
      dma_active = 0;
   endtask

   task automatic t_unexp();
      do_reset();
      csr_write(64'h1);
      unexp_type = 1; @(negedge clk); unexp_type = 0;
      chk({csr_rd_data[36:32], err_o}, {5'b00001, 1'b1}, "R6 unexp flag and R7 err");
      csr_write(64'h1);
      chk({csr_rd_data[36:32], err_o}, {5'b00001, 1'b1}, "R2 write 0 keeps flag");
      csr_write(64'h1_0000_0001);
      chk({csr_rd_data[36:32], err_o}, {5'b00000, 1'b0}, "R2 w1c clears R7 err drops");
   endtask

   task automatic t_resp();
      do_reset();
      csr_write(64'h8);
      resp_excep = 1; @(negedge clk); resp_excep = 0;
      chk({csr_rd_data[36:32], err_o}, {5'b01000, 1'b1}, "R6 resp flag");
      csr_write(64'h0);
      chk({59'd0, csr_rd_data[36:32], err_o}, {59'd0, 5'b01000, 1'b0}, "R7 err gated by enable");
   endtask

   task automatic t_pioerr();
      do_reset();
      csr_write(64'h110);
      dma_active = 1; dev_rdata = 8'h11;
      host_req = 1; host_wr = 0; #1;
      chk({dev_req, host_rdata}, {1'b1, 8'h11}, "R8 not blocked");
      @(negedge clk);
      host_req = 0;
      chk({csr_rd_data[36:32], err_o, smi_req}, {5'b10000, 1'b1, 1'b0}, "R8 flag36 err");
      dma_active = 0;
   endtask

   task automatic t_smiwr();
      do_reset();
      csr_write(64'h102);
      dma_active = 1;
      host_req = 1; host_wr = 1; #1;
      chk({63'd0, dev_req}, 64'h0, "R9 write still blocked");
      @(negedge clk);
      host_req = 0; host_wr = 0;
      chk({csr_rd_data[36:32], smi_req, err_o}, {5'b00010, 1'b1, 1'b0}, "R9 flag33 smi");
      dma_active = 0;
      @(negedge clk);
      chk({63'd0, smi_req}, 64'h1, "R10 smi held");
      smi_ack = 1; @(negedge clk); smi_ack = 0;
      chk({63'd0, smi_req}, 64'h0, "R10 smi dropped on ack");
   endtask

   task automatic t_stale();
      do_reset();
      csr_write(64'h106);
      dma_active = 1;
      pio(1'b1);
      chk({csr_rd_data[36:32], smi_req, err_o}, {5'b00010, 1'b1, 1'b0}, "R11 first smi");
      pio(1'b1);
      chk({csr_rd_data[36:32], smi_req, err_o}, {5'b00110, 1'b1, 1'b1}, "R11 stale flag34");
      smi_ack = 1; host_req = 1; host_wr = 1;
      @(negedge clk);
      smi_ack = 0; host_req = 0; host_wr = 0;
      chk({63'd0, smi_req}, 64'h1, "R10 raise with ack keeps smi");
      dma_active = 0;
   endtask

   task automatic t_race();
      do_reset();
      csr_write(64'h1);
      unexp_type = 1; csr_wr_en = 1; csr_wr_data = 64'h1_0000_0001;
      @(negedge clk);
      unexp_type = 0; csr_wr_en = 0; csr_wr_data = '0;
      chk({63'd0, csr_rd_data[32]}, 64'h1, "R12 event beats clear");
   endtask

   task automatic t_smipio();
      do_reset();
      smi_pio_en = 1; dma_active = 1; dev_rdata = 8'h42;
      csr_write(64'h100);
      host_req = 1; host_wr = 0; #1;
      chk({dev_req, host_rdata}, {1'b1, 8'h42}, "R13 access passes");
      @(negedge clk);
      host_req = 0;
      chk({58'd0, csr_rd_data[36:32], smi_req}, {58'd0, 5'b0, 1'b1}, "R13 smi raised");
      smi_pio_en = 0; dma_active = 0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      t_reset();
      t_csr();
      t_pass();
      t_block();
      t_gate();
      t_unexp();
      t_resp();
      t_pioerr();
      t_smiwr();
      t_stale();
      t_race();
      t_smipio();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule